// File: doc/BRIEF.md
# Transmit Overhead Error Injector

This block sits in the byte-wide transmit path of a SONET/SDH framer. The frame generator upstream supplies each outgoing byte together with a frame-start marker and strobes that mark the first A2 framing byte, the B1 parity byte and every B2 parity byte. Under static control inputs, the injector deliberately corrupts these bytes so that a far-end receiver's framing and parity monitors can be tested. Parity computation, scrambling and frame building all happen outside this block.

Three kinds of corruption are available. A programmable burst inverts the first A2 byte in a chosen number of consecutive frames. A separate control inverts the B1 byte. A third control inverts all B2 bytes. A bypass control forces every byte through unchanged. A scramble-inhibit control is passed on, registered, to the scrambler downstream. Every output is registered, so data, frame marker and inhibit flag all leave the block one cycle after they enter.

Top module: `txoh_err_inj`

## Requirements
- R1: While reset is asserted, and directly after it, dataOut, frameStartOut, scrInhibitOut and a2Remaining are all 0. No burst is pending, and every control input is taken as 0.
- R2: Each input byte appears on dataOut exactly one clock later, and frameStartOut is frameStartIn delayed by one clock. A byte that no active insertion selects comes out unchanged.
- R3: A pulse on cfgA2Write with a nonzero cfgA2Count N arms a burst that starts at the next frameStartIn. The byte flagged by isA2First is then sent with all bits inverted (0x28 becomes 0xD7) in exactly N consecutive frames, and the frames after them are left untouched.
- R4: a2Remaining holds N during the first frame of a burst and drops by one at each later frame start, counting down to 0 and staying there. A nonzero write does not change a2Remaining until the next frame start.
- R5: A pulse on cfgA2Write with cfgA2Count equal to 0 cancels any pending or running burst. a2Remaining reads 0 on the next clock, and no further A2 byte is inverted.
- R6: While cfgB1Inv is 1, the byte flagged by isB1 is sent with all bits inverted.
- R7: While cfgB2Inv is 1, every byte flagged by isB2 in the frame is sent with all bits inverted.
- R8: While cfgBypass is 1, dataOut equals dataIn one clock earlier for every byte, whatever the insertion controls are set to.
- R9: scrInhibitOut is cfgScrInhibit delayed by one clock. A 1 tells the downstream scrambler to stop scrambling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataIn | input | DATA_W | Outgoing byte from the frame generator |
| frameStartIn | input | 1 | High on the first byte of a frame |
| isA2First | input | 1 | High on the first A2 framing byte |
| isB1 | input | 1 | High on the B1 parity byte |
| isB2 | input | 1 | High on each B2 parity byte |
| cfgA2Write | input | 1 | One-cycle write strobe for the A2 burst length |
| cfgA2Count | input | CNT_W | A2 burst length in frames; 0 cancels the burst |
| cfgB1Inv | input | 1 | Invert the B1 byte |
| cfgB2Inv | input | 1 | Invert all B2 bytes |
| cfgBypass | input | 1 | Pass every byte through unchanged |
| cfgScrInhibit | input | 1 | Request that scrambling be inhibited |
| dataOut | output | DATA_W | Outgoing byte, delayed by one cycle |
| frameStartOut | output | 1 | Frame-start marker aligned with dataOut |
| scrInhibitOut | output | 1 | Registered scramble-inhibit flag |
| a2Remaining | output | CNT_W | Frames left in the current A2 burst |

## Verification
The bench builds the block with its defaults, DATA_W = 8 and CNT_W = 5, and drives short twelve-byte frames, so each frame takes only a few cycles. This makes it cheap to run a three-frame A2 burst to the end and past it, to cancel a burst part way through, and to set the B1, B2 and bypass controls against overlapping A2 bursts. A 5-bit count keeps the counter's zero floor and the arm-then-load order within a handful of frames.

// File: rtl/txoh_err_inj_pkg.sv
package txoh_err_inj_pkg;
  // Per-byte strobes handed from the control unit to the datapath.
  typedef struct packed {
    logic invertByte;
    logic frameMark;
    logic scrInhibit;
  } injStrobe_t;
endpackage

// File: rtl/txoh_err_inj_ctrl.sv
module txoh_err_inj_ctrl
  import txoh_err_inj_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStartIn,
  input  logic             isA2First,
  input  logic             isB1,
  input  logic             isB2,
  input  logic             cfgA2Write,
  input  logic [CNT_W-1:0] cfgA2Count,
  input  logic             cfgB1Inv,
  input  logic             cfgB2Inv,
  input  logic             cfgBypass,
  input  logic             cfgScrInhibit,
  output injStrobe_t       strobes,
  output logic [CNT_W-1:0] remaining
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             armed;
  logic [CNT_W-1:0] pending;
  logic [CNT_W-1:0] curLeft;
  logic [CNT_W-1:0] nextLeft;
  logic [CNT_W-1:0] effLeft;
  logic             a2Hit;
  logic             b1Hit;
  logic             b2Hit;

  // Value the burst counter takes at a frame start.
  always_comb begin
    if (armed)                nextLeft = pending;
    else if (curLeft != ZERO) nextLeft = curLeft - ONE;
    else                      nextLeft = ZERO;
  end

  // The count that applies to the byte now on the input.
  assign effLeft = frameStartIn ? nextLeft : curLeft;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed   <= 1'b0;
      pending <= ZERO;
      curLeft <= ZERO;
    end else if (cfgA2Write) begin
      if (cfgA2Count == ZERO) begin
        armed   <= 1'b0;
        curLeft <= ZERO;
      end else begin
        armed   <= 1'b1;
        pending <= cfgA2Count;
      end
    end else if (frameStartIn) begin
      armed   <= 1'b0;
      curLeft <= nextLeft;
    end
  end

  assign a2Hit = isA2First && (effLeft != ZERO);
  assign b1Hit = isB1 && cfgB1Inv;
  assign b2Hit = isB2 && cfgB2Inv;

  always_comb begin
    strobes.invertByte = !cfgBypass && (a2Hit || b1Hit || b2Hit);
    strobes.frameMark  = frameStartIn;
    strobes.scrInhibit = cfgScrInhibit;
  end

  assign remaining = curLeft;
endmodule

// File: rtl/txoh_err_inj_dp.sv
module txoh_err_inj_dp
  import txoh_err_inj_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  injStrobe_t        strobes,
  output logic [DATA_W-1:0] dataOut,
  output logic              frameStartOut,
  output logic              scrInhibitOut
);
  logic [DATA_W-1:0] mask;

  // Build the inversion mask one bit lane at a time.
  for (genvar i = 0; i < DATA_W; i++) begin : g_lane
    assign mask[i] = strobes.invertByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut       <= '0;
      frameStartOut <= 1'b0;
      scrInhibitOut <= 1'b0;
    end else begin
      dataOut       <= dataIn ^ mask;
      frameStartOut <= strobes.frameMark;
      scrInhibitOut <= strobes.scrInhibit;
    end
  end
endmodule

// File: rtl/txoh_err_inj.sv
module txoh_err_inj
  import txoh_err_inj_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              frameStartIn,
  input  logic              isA2First,
  input  logic              isB1,
  input  logic              isB2,
  input  logic              cfgA2Write,
  input  logic [CNT_W-1:0]  cfgA2Count,
  input  logic              cfgB1Inv,
  input  logic              cfgB2Inv,
  input  logic              cfgBypass,
  input  logic              cfgScrInhibit,
  output logic [DATA_W-1:0] dataOut,
  output logic              frameStartOut,
  output logic              scrInhibitOut,
  output logic [CNT_W-1:0]  a2Remaining
);
  injStrobe_t strobes;

  txoh_err_inj_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStartIn(frameStartIn),
    .isA2First(isA2First), .isB1(isB1), .isB2(isB2),
    .cfgA2Write(cfgA2Write), .cfgA2Count(cfgA2Count),
    .cfgB1Inv(cfgB1Inv), .cfgB2Inv(cfgB2Inv), .cfgBypass(cfgBypass),
    .cfgScrInhibit(cfgScrInhibit), .strobes(strobes), .remaining(a2Remaining)
  );

  txoh_err_inj_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .strobes(strobes),
    .dataOut(dataOut), .frameStartOut(frameStartOut), .scrInhibitOut(scrInhibitOut)
  );
endmodule

// File: rtl/txoh_err_inj_chk.sv
module txoh_err_inj_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] dataIn,
  input logic              frameStartIn,
  input logic              isA2First,
  input logic              isB1,
  input logic              isB2,
  input logic              cfgA2Write,
  input logic [CNT_W-1:0]  cfgA2Count,
  input logic              cfgB1Inv,
  input logic              cfgB2Inv,
  input logic              cfgBypass,
  input logic              cfgScrInhibit,
  input logic [DATA_W-1:0] dataOut,
  input logic              frameStartOut,
  input logic              scrInhibitOut,
  input logic [CNT_W-1:0]  a2Remaining
);
  a_r2_frame_delay: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> frameStartOut == $past(frameStartIn));

  a_r8_bypass_untouched: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cfgBypass)) |-> dataOut == $past(dataIn));

  a_r6_b1_inverted: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(isB1 && cfgB1Inv && !cfgBypass))
      |-> dataOut == ~$past(dataIn));

  a_r7_b2_inverted: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(isB2 && cfgB2Inv && !cfgBypass))
      |-> dataOut == ~$past(dataIn));

  a_r5_cancel_clears: assert property (@(posedge clk) disable iff (!rstN)
    (cfgA2Write && cfgA2Count == '0) |=> a2Remaining == '0);

  a_r4_holds_between_frames: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgA2Write && !frameStartIn) |=> $stable(a2Remaining));

  a_r9_inhibit_delay: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> scrInhibitOut == $past(cfgScrInhibit));
endmodule

bind txoh_err_inj txoh_err_inj_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/txoh_err_inj_bench.sv
module txoh_err_inj_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 5;
  localparam int FRAME_LEN = 12;

  typedef struct {
    logic [DATA_W-1:0] data;
    logic              fs;
    string             req;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [DATA_W-1:0] dataIn = '0;
  logic frameStartIn = 1'b0, isA2First = 1'b0, isB1 = 1'b0, isB2 = 1'b0;
  logic cfgA2Write = 1'b0;
  logic [CNT_W-1:0] cfgA2Count = '0;
  logic cfgB1Inv = 1'b0, cfgB2Inv = 1'b0, cfgBypass = 1'b0, cfgScrInhibit = 1'b0;
  logic [DATA_W-1:0] dataOut;
  logic frameStartOut, scrInhibitOut;
  logic [CNT_W-1:0] a2Remaining;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txoh_err_inj #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_txoh_err_inj (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: at each falling edge, compare the output against the byte driven one cycle earlier.
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      expItem_t it;
      it = expQ.pop_front();
      check(it.req, {24'h0, dataOut}, {24'h0, it.data});
      check("R2 frame marker", {31'h0, frameStartOut}, {31'h0, it.fs});
    end
  end

  // Driver: one byte per cycle, with its expected output pushed to the scoreboard.
  task automatic sendByte(input logic [7:0] d, input logic fs, input logic a2,
                          input logic b1, input logic b2, input logic inv,
                          input string req, input logic wr = 1'b0,
                          input logic [CNT_W-1:0] cnt = '0);
    expItem_t it;
    @(negedge clk); #1;
    dataIn = d; frameStartIn = fs; isA2First = a2; isB1 = b1; isB2 = b2;
    cfgA2Write = wr; cfgA2Count = cnt;
    it.data = inv ? ~d : d; it.fs = fs; it.req = req;
    expQ.push_back(it);
  endtask

  // A short frame: A1,A1,A2(first),A2,B1,pad,B2,B2,payload...
  task automatic sendFrame(input logic expA2, input logic expB1, input logic expB2,
                           input logic [7:0] seed, input int expRem);
    for (int i = 0; i < FRAME_LEN; i++) begin
      case (i)
        0: sendByte(8'hF6, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 A1 byte");
        1: sendByte(8'hF6, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 A1 byte");
        2: sendByte(8'h28, 1'b0, 1'b1, 1'b0, 1'b0, expA2, "R3 first A2");
        3: sendByte(8'h28, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 second A2");
        4: sendByte(seed ^ 8'h5A, 1'b0, 1'b0, 1'b1, 1'b0, expB1, "R6 B1 byte");
        6: sendByte(seed ^ 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1, expB2, "R7 B2 byte");
        7: sendByte(seed ^ 8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, expB2, "R7 B2 byte");
        default: sendByte(seed + 8'(i), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 payload");
      endcase
      if (i == 1 && expRem >= 0)
        check("R4 remaining count", {27'h0, a2Remaining}, expRem);
    end
  endtask

  task automatic idleWrite(input logic [CNT_W-1:0] cnt);
    sendByte(8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 idle", 1'b1, cnt);
    sendByte(8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 idle");
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 dataOut", {24'h0, dataOut}, 32'h0);
    check("R1 frameStartOut", {31'h0, frameStartOut}, 32'h0);
    check("R1 scrInhibitOut", {31'h0, scrInhibitOut}, 32'h0);
    check("R1 a2Remaining", {27'h0, a2Remaining}, 32'h0);
    #1 rstN = 1'b1;

    // R2: clean frames with no insertion
    sendFrame(1'b0, 1'b0, 1'b0, 8'h10, 0);
    sendFrame(1'b0, 1'b0, 1'b0, 8'hA7, 0);

    // R3/R4: a three-frame burst
    idleWrite(5'd3);
    check("R4 no change before frame start", {27'h0, a2Remaining}, 32'h0);
    sendFrame(1'b1, 1'b0, 1'b0, 8'h20, 3);
    sendFrame(1'b1, 1'b0, 1'b0, 8'h21, 2);
    sendFrame(1'b1, 1'b0, 1'b0, 8'h22, 1);
    sendFrame(1'b0, 1'b0, 1'b0, 8'h23, 0);
    sendFrame(1'b0, 1'b0, 1'b0, 8'h24, 0);

    // R5: cancel a running burst
    idleWrite(5'd4);
    sendFrame(1'b1, 1'b0, 1'b0, 8'h30, 4);
    idleWrite(5'd0);
    check("R5 remaining cleared", {27'h0, a2Remaining}, 32'h0);
    sendFrame(1'b0, 1'b0, 1'b0, 8'h31, 0);

    // R6/R7: parity byte inversion
    cfgB1Inv = 1'b1;
    sendFrame(1'b0, 1'b1, 1'b0, 8'h40, 0);
    cfgB1Inv = 1'b0; cfgB2Inv = 1'b1;
    sendFrame(1'b0, 1'b0, 1'b1, 8'h41, 0);
    cfgB1Inv = 1'b1;
    idleWrite(5'd1);
    sendFrame(1'b1, 1'b1, 1'b1, 8'h42, 1);

    // R8: bypass overrides every insertion
    idleWrite(5'd2);
    cfgBypass = 1'b1;
    sendFrame(1'b0, 1'b0, 1'b0, 8'h50, 2);
    cfgBypass = 1'b0; cfgB1Inv = 1'b0; cfgB2Inv = 1'b0;
    idleWrite(5'd0);

    // R9: scramble inhibit pass-through
    cfgScrInhibit = 1'b1;
    sendByte(8'h66, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 idle");
    @(negedge clk);
    check("R9 inhibit set", {31'h0, scrInhibitOut}, 32'h1);
    #1 cfgScrInhibit = 1'b0;
    @(negedge clk);
    check("R9 inhibit clear", {31'h0, scrInhibitOut}, 32'h0);

    sendFrame(1'b0, 1'b0, 1'b0, 8'h70, 0);
    repeat (3) @(negedge clk);
    #2 finish();
  end
endmodule